// File: doc/BRIEF.md
# Preemptive backoff bus master

This block is a second bus master on a bus owned by a primary processor. It does not ask for the bus and wait for a grant. It takes the bus by driving an active-low backoff line, which makes the primary master float its outputs. It then runs one single-transfer read or write of its own and releases backoff, so the primary master can restart whatever it was doing.

On the user side, a one-clock request carries the address, the direction and the write data. The block answers with a one-clock acknowledge and, later, a one-clock done pulse that comes with the read data. On the bus side it watches the primary address strobe and both memory ready strobes (single and burst) to tell whether a primary cycle is outstanding.

- If a primary cycle is outstanding, the block waits for memory to return a ready before it issues its own strobe.
- If the bus is quiet, it issues its strobe a fixed number of clocks after asserting backoff.

Primary strobes seen while backoff is held are treated as stranded and never counted as a new primary cycle.

Top module: `bom_master`

## Requirements
- R1: After reset `boff_n_o`=1, `ads_n_o`=1, `oe_o`=0, `busy_o`=0, `ack_o`=0 and `done_o`=0.
- R2: A request sampled while idle produces, in the next cycle, `ack_o`=1 for exactly one cycle, `boff_n_o`=0 and `busy_o`=1.
- R3: If no primary cycle is outstanding when the request is taken, `ads_n_o` goes low two clocks after `boff_n_o` first goes low (GAP_CLKS=2).
- R4: A primary cycle is outstanding if `pm_ads_n_i` was sampled low after the last ready, or is sampled low on the same edge as the request. In that case `ads_n_o` stays high until `rdy_n_i` or `brdy_n_i` is sampled low, and goes low in the cycle after that sample.
- R5: The block's own `ads_n_o` is low for exactly one cycle. `addr_o`, `we_o` (1 = write) and `wdata_o` carry the request values, with `oe_o`=1, from that cycle until the ready is sampled.
- R6: `rdy_n_i` sampled low after the strobe cycle ends the cycle. In the next cycle `done_o`=1 for one cycle and `boff_n_o`=1. On a read, `rdata_o` equals `dat_i` at that sample. `brdy_n_i` during the block's own cycle has no effect.
- R7: `boff_n_o` stays low on every cycle from the acknowledge until the completing ready.
- R8: A request sampled while busy is dropped: no acknowledge, and the running cycle's address is unchanged.
- R9: `pm_ads_n_i` sampled low while backoff is asserted (a stranded strobe) does not make the next request wait for a ready.
- R10: When not driving, `oe_o`=0, `ads_n_o`=1 and `addr_o`, `we_o` and `wdata_o` are zero. `oe_o` is never 1 while `boff_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-clock request pulse |
| req_we_i | input | 1 | Request direction, 1 = write |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Request write data |
| ack_o | output | 1 | Request accepted pulse |
| busy_o | output | 1 | Alternate cycle in progress |
| done_o | output | 1 | Cycle completed pulse |
| rdata_o | output | DW | Read data from the last read |
| pm_ads_n_i | input | 1 | Primary master address strobe, active low |
| rdy_n_i | input | 1 | Single ready, active low |
| brdy_n_i | input | 1 | Burst ready, active low |
| dat_i | input | DW | Bus data returned by memory |
| boff_n_o | output | 1 | Backoff request, active low |
| ads_n_o | output | 1 | Own address strobe, active low |
| addr_o | output | AW | Own address |
| we_o | output | 1 | Own write enable |
| wdata_o | output | DW | Own write data |
| oe_o | output | 1 | Bus drive enable (0 = outputs floated) |

## Verification
The bench targets the start-of-cycle decision:

- A request taken on the very edge where the primary strobe appears must wait for a ready. A design that sampled the strobe one clock late would drive into a live primary cycle.
- A quiet-bus request must strobe exactly two clocks after backoff. Early would violate the handshake window; late would waste bus time.
- A stranded primary strobe during backoff must not leave a false outstanding cycle. If it did, the next quiet-bus request would hang waiting for a ready.
- Burst readies inside the block's own cycle must not end it early.
- A request that arrives while busy must neither be acknowledged nor disturb the held address.

// File: rtl/bom_pkg.sv
package bom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_GAP,
        ST_ADDR,
        ST_DATA
    } bom_state_e;
endpackage

// File: rtl/bom_track.sv
module bom_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pm_ads_n_i,
    input  logic rdy_n_i,
    input  logic brdy_n_i,
    input  logic boff_active_i,
    output logic inflight_o
);
    logic inflight_d, inflight_q;
    logic any_rdy;

    always_comb begin
        any_rdy    = !rdy_n_i || !brdy_n_i;
        // outstanding now: a tracked cycle not yet readied, or a fresh strobe
        inflight_o = (inflight_q && !any_rdy) || !pm_ads_n_i;
        // strobes seen while the primary is floated are stranded: drop them
        inflight_d = boff_active_i ? 1'b0 : inflight_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= 1'b0;
        else        inflight_q <= inflight_d;
    end

    // R9: while backoff is held no primary cycle is remembered
    p_stranded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (boff_active_i && !pm_ads_n_i) |=> !inflight_q);
endmodule

// File: rtl/bom_seq.sv
module bom_seq
    import bom_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int GAP_CLKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          req_we_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic          inflight_i,
    input  logic          rdy_n_i,
    input  logic          brdy_n_i,
    input  logic [DW-1:0] dat_i,
    output logic          ack_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic          boff_n_o,
    output logic          ads_n_o,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic [DW-1:0] wdata_o,
    output logic          oe_o
);
    localparam int CW = $clog2(GAP_CLKS + 1);

    typedef struct packed {
        bom_state_e    state;
        logic [CW-1:0] cnt;
        logic          boff;
        logic [AW-1:0] addr;
        logic          we;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          ack;
        logic          done;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: if (req_i) begin
                r_d.ack   = 1'b1;
                r_d.boff  = 1'b1;
                r_d.addr  = req_addr_i;
                r_d.we    = req_we_i;
                r_d.wdata = req_wdata_i;
                r_d.cnt   = '0;
                r_d.state = inflight_i ? ST_WAIT : ST_GAP;
            end
            ST_WAIT: if (!rdy_n_i || !brdy_n_i) r_d.state = ST_ADDR;
            ST_GAP: begin
                if (r_q.cnt == CW'(GAP_CLKS - 1)) r_d.state = ST_ADDR;
                else                              r_d.cnt   = r_q.cnt + 1'b1;
            end
            ST_ADDR: r_d.state = ST_DATA;
            ST_DATA: if (!rdy_n_i) begin
                r_d.state = ST_IDLE;
                r_d.boff  = 1'b0;
                r_d.done  = 1'b1;
                if (!r_q.we) r_d.rdata = dat_i;
                r_d.addr  = '0;
                r_d.we    = 1'b0;
                r_d.wdata = '0;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        oe_o     = (r_q.state == ST_ADDR) || (r_q.state == ST_DATA);
        ads_n_o  = !(r_q.state == ST_ADDR);
        addr_o   = oe_o ? r_q.addr  : '0;
        we_o     = oe_o & r_q.we;
        wdata_o  = oe_o ? r_q.wdata : '0;
        boff_n_o = !r_q.boff;
        busy_o   = r_q.state != ST_IDLE;
        ack_o    = r_q.ack;
        done_o   = r_q.done;
        rdata_o  = r_q.rdata;
    end

    p_ack_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (busy_o && !boff_n_o));
    p_ads_boff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n_o |-> !boff_n_o);
    p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && rdy_n_i && brdy_n_i) |=> ads_n_o);
    p_ads_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n_o |=> ads_n_o);
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && $past(oe_o)) |-> $stable(addr_o));
    p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (boff_n_o && !oe_o));
    p_boff_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(r_q.state == ST_DATA && !rdy_n_i)) |=> !boff_n_o);
    p_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> !boff_n_o);
endmodule

// File: rtl/bom_master.sv
module bom_master #(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int GAP_CLKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          req_we_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          ack_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    input  logic          pm_ads_n_i,
    input  logic          rdy_n_i,
    input  logic          brdy_n_i,
    input  logic [DW-1:0] dat_i,
    output logic          boff_n_o,
    output logic          ads_n_o,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic [DW-1:0] wdata_o,
    output logic          oe_o
);
    logic inflight;

    bom_track u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .pm_ads_n_i    (pm_ads_n_i),
        .rdy_n_i       (rdy_n_i),
        .brdy_n_i      (brdy_n_i),
        .boff_active_i (!boff_n_o),
        .inflight_o    (inflight)
    );

    bom_seq #(.AW(AW), .DW(DW), .GAP_CLKS(GAP_CLKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .req_we_i    (req_we_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .inflight_i  (inflight),
        .rdy_n_i     (rdy_n_i),
        .brdy_n_i    (brdy_n_i),
        .dat_i       (dat_i),
        .ack_o       (ack_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rdata_o     (rdata_o),
        .boff_n_o    (boff_n_o),
        .ads_n_o     (ads_n_o),
        .addr_o      (addr_o),
        .we_o        (we_o),
        .wdata_o     (wdata_o),
        .oe_o        (oe_o)
    );
endmodule

// File: tb/bom_master_tb.sv
module bom_master_tb;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ack, busy, done;
    logic [DW-1:0] rdata;
    logic          pm_ads_n = 1'b1, rdy_n = 1'b1, brdy_n = 1'b1;
    logic [DW-1:0] dat = '0;
    logic          boff_n, ads_n, we, oe;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bom_master #(.AW(AW), .DW(DW), .GAP_CLKS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ack_o(ack),
        .busy_o(busy), .done_o(done), .rdata_o(rdata), .pm_ads_n_i(pm_ads_n),
        .rdy_n_i(rdy_n), .brdy_n_i(brdy_n), .dat_i(dat), .boff_n_o(boff_n),
        .ads_n_o(ads_n), .addr_o(addr), .we_o(we), .wdata_o(wdata), .oe_o(oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic bit expect_wait(input int pmode);
        return pmode != 0;
    endfunction

    // pmode: 0 quiet bus, 1 primary strobe one edge earlier, 2 strobe on the request edge
    task automatic run(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input int pmode, input int pwait, input bit use_burst,
                       input int lat, input logic [DW-1:0] rd,
                       input bit busy_req, input bit strand);
        if (pmode == 1) begin
            pm_ads_n = 1'b0; step(); pm_ads_n = 1'b1;
        end
        req = 1'b1; req_we = w; req_addr = a; req_wdata = wd;
        if (pmode == 2) pm_ads_n = 1'b0;
        step();
        req = 1'b0; pm_ads_n = 1'b1;
        chk(ack == 1'b1, "R2 ack", ack, 1);
        chk(boff_n == 1'b0, "R2 backoff", boff_n, 0);
        chk(busy == 1'b1, "R2 busy", busy, 1);
        if (!expect_wait(pmode)) begin
            chk(ads_n == 1'b1, "R3 no early strobe", ads_n, 1);
            step();
            chk(ack == 1'b0, "R2 ack one cycle", ack, 0);
            chk(ads_n == 1'b1, "R3 no early strobe", ads_n, 1);
            step();
            chk(ads_n == 1'b0, "R3 strobe two clocks after backoff", ads_n, 0);
        end else begin
            for (int i = 0; i < pwait; i++) begin
                chk(ads_n == 1'b1, "R4 waiting for ready", ads_n, 1);
                step();
            end
            chk(ads_n == 1'b1, "R4 waiting for ready", ads_n, 1);
            if (use_burst) brdy_n = 1'b0; else rdy_n = 1'b0;
            step();
            rdy_n = 1'b1; brdy_n = 1'b1;
            chk(ads_n == 1'b0, "R4 strobe after ready", ads_n, 0);
        end
        chk(oe == 1'b1, "R5 drive", oe, 1);
        chk(addr == a, "R5 addr", addr, a);
        chk(we == w, "R5 we", we, w);
        chk(wdata == (w ? wd : wd), "R5 wdata", wdata, wd);
        step();
        chk(ads_n == 1'b1, "R5 strobe one cycle", ads_n, 1);
        for (int i = 0; i < lat; i++) begin
            brdy_n   = 1'($urandom_range(0, 1));
            pm_ads_n = (strand && i == 0) ? 1'b0 : 1'b1;
            req      = busy_req && i == 0;
            req_addr = ~a;
            step();
            req = 1'b0; brdy_n = 1'b1; pm_ads_n = 1'b1;
            chk(ack == 1'b0, "R8 no ack while busy", ack, 0);
            chk(addr == a, "R8 address held", addr, a);
            chk(ads_n == 1'b1, "R5 strobe stays high", ads_n, 1);
            chk(boff_n == 1'b0, "R7 backoff held", boff_n, 0);
            chk(done == 1'b0, "R6 burst ready ignored", done, 0);
        end
        rdy_n = 1'b0; dat = rd;
        step();
        rdy_n = 1'b1;
        chk(done == 1'b1, "R6 done", done, 1);
        chk(boff_n == 1'b1, "R6 release", boff_n, 1);
        chk(oe == 1'b0, "R10 floated", oe, 0);
        chk(addr == '0, "R10 addr zero", addr, 0);
        if (!w) chk(rdata == rd, "R6 read data", rdata, rd);
        step();
        chk(done == 1'b0, "R6 done one cycle", done, 0);
        chk(busy == 1'b0, "R6 idle", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step(); step();
        chk(boff_n == 1'b1, "R1 backoff", boff_n, 1);
        chk(ads_n == 1'b1, "R1 strobe", ads_n, 1);
        chk(oe == 1'b0, "R1 drive", oe, 0);
        chk(busy == 1'b0 && ack == 1'b0 && done == 1'b0, "R1 status", {busy, ack, done}, 0);
        rst_n = 1'b1;
        step();
        chk(boff_n == 1'b1 && oe == 1'b0, "R1 after reset", {boff_n, oe}, 2'b10);
        // directed corner cases
        run(1'b1, 32'h0000_1000, 32'hdead_beef, 0, 0, 1'b0, 0, '0, 1'b0, 1'b0);
        run(1'b0, 32'h0000_2004, 32'h0, 0, 0, 1'b0, 3, 32'h1234_5678, 1'b0, 1'b0);
        run(1'b0, 32'h0000_3008, 32'h0, 1, 4, 1'b0, 2, 32'hcafe_f00d, 1'b0, 1'b0);
        run(1'b1, 32'h0000_400c, 32'h55aa_55aa, 2, 2, 1'b1, 1, '0, 1'b0, 1'b0);
        run(1'b1, 32'h0000_5010, 32'h0bad_0bad, 0, 0, 1'b0, 3, '0, 1'b1, 1'b0);
        // R9: stranded strobe during backoff, then a quiet-bus request
        run(1'b0, 32'h0000_6014, 32'h0, 0, 0, 1'b0, 2, 32'h0f0f_0f0f, 1'b0, 1'b1);
        run(1'b0, 32'h0000_7018, 32'h0, 0, 0, 1'b0, 1, 32'hf0f0_f0f0, 1'b0, 1'b0);
        // constrained random
        for (int n = 0; n < 40; n++) begin
            run(1'($urandom_range(0, 1)), $urandom(), $urandom(),
                $urandom_range(0, 2), $urandom_range(0, 5), 1'($urandom_range(0, 1)),
                $urandom_range(0, 6), $urandom(),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            repeat ($urandom_range(0, 2)) step();
        end
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule